// File: doc/BRIEF.md
# Execute Stage with Condition Flags

This block is the execute step of a five-step scalar pipeline. Each accepted operation carries a 5-bit opcode, two register operands (`in_a`, `in_b`), an immediate (`in_imm`) and the program counter captured when the operation was fetched (`in_pc`). The stage computes one result word that takes the place of the first operand. That word can be an arithmetic or logic value, a memory effective address, a jump target or a branch verdict. The stage keeps four condition flags: greater-than, equal, underflow and overflow.

Compares write the greater-than and equal flags. Signed add, subtract and multiply forms write the underflow and overflow flags. The four conditional branches test one flag each. A taken branch returns its target folded into a power-of-two address space. A branch that is not taken returns all ones. The branch target is formed from the PC that travelled with the operation, so the live fetch PC is never used. One output register separates the stage from the next one. A valid/ready pair on each side lets a downstream stall hold the stage without losing or repeating work.

Top module: `xu_exec`

## Requirements
- R1: Opcode codes are NOP=0, ADD=1, SUB=2, MUL=3, QUOT=4, REM=5, SHR=6, SHL=7, AND=8, OR=9, XOR=10, NOT=11. ADD, SUB, MUL (low word), AND, OR and XOR return `in_a` combined with `in_b`. NOT returns the bitwise inverse of `in_a`.
- R2: Opcodes ADDI=12, SUBI=13, SHRI=14, SHLI=15, ANDI=16, ORI=17, XORI=18 behave like their register forms, with `in_imm` in place of `in_b`.
- R3: Right shifts are arithmetic and left shifts are logical. The shift count is the low log2(DATA_W) bits of the second operand.
- R4: QUOT returns the signed quotient rounded toward zero. REM returns the signed remainder, which takes the sign of the dividend. Both return zero when the divisor is zero.
- R5: LOAD=19 and STORE=20 return `in_a + in_imm`. JMP=22 and JAL=23 return `in_a + in_b`. JRL=24 returns `in_pc + in_b`.
- R6: CMP=21 sets the greater-than flag to (signed `in_a` > signed `in_b`) and the equal flag to (`in_a` == `in_b`). It returns `in_a` unchanged.
- R7: ADD, SUB, MUL, ADDI and SUBI compute the exact signed result. They set overflow when that result is above the largest DATA_W-bit signed value, and underflow when it is below the smallest. Both are cleared otherwise.
- R8: BEQ=25, BGT=26, BUF=27 and BOF=28 test the equal, greater-than, underflow and overflow flag in that order. When the flag is set the result is the low ADDR_W bits of `in_pc + in_b`, zero-extended. When the flag is clear the result is all ones. The flags read are those in place before the branch is accepted.
- R9: NOP, code 29 (vector, push and pop class) and the unused codes 30 and 31 return `in_a` unchanged and leave every flag unchanged.
- R10: An operation is accepted on a rising edge with `in_valid` and `in_ready` both high. Its result and `out_valid` appear after that edge. `in_ready` is high when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the result is held and nothing is accepted.
- R11: `out_flags` is {overflow, underflow, equal, greater-than}, from bit 3 down to bit 0. Reset clears it to 0 and clears `out_valid`. The flags change only on the edge that accepts a flag-writing operation. CMP leaves underflow and overflow alone, and the arithmetic forms leave greater-than and equal alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers an operation |
| in_ready | output | 1 | Stage can take an operation this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand or branch/jump offset |
| in_imm | input | DATA_W | Immediate operand |
| in_pc | input | DATA_W | PC recorded at fetch |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Downstream takes the result |
| out_res | output | DATA_W | Result word |
| out_flags | output | 4 | Condition flags {OF, UF, EQ, GT} |

## Verification
The bench builds the stage with DATA_W=8 and ADDR_W=4. With those values every first-operand value can be applied against a set of second operands that includes zero, plus and minus one, both signed extremes and a mixed pattern, and every one of the 32 opcodes runs on each pair. The 8-bit width makes signed overflow and underflow on add, subtract and multiply common. It also reaches division of the most negative value by minus one and every shift count. The 4-bit address space makes branch targets wrap often. Because compares, arithmetic and branches are interleaved on each operand pair, branches see many flag combinations. Directed steps cover reset, a held stall with a new compare waiting, and an idle bubble.

// File: rtl/xu_pkg.sv
package xu_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_MUL   = 5'd3,
    OP_QUOT  = 5'd4,
    OP_REM   = 5'd5,
    OP_SHR   = 5'd6,
    OP_SHL   = 5'd7,
    OP_AND   = 5'd8,
    OP_OR    = 5'd9,
    OP_XOR   = 5'd10,
    OP_NOT   = 5'd11,
    OP_ADDI  = 5'd12,
    OP_SUBI  = 5'd13,
    OP_SHRI  = 5'd14,
    OP_SHLI  = 5'd15,
    OP_ANDI  = 5'd16,
    OP_ORI   = 5'd17,
    OP_XORI  = 5'd18,
    OP_LOAD  = 5'd19,
    OP_STORE = 5'd20,
    OP_CMP   = 5'd21,
    OP_JMP   = 5'd22,
    OP_JAL   = 5'd23,
    OP_JRL   = 5'd24,
    OP_BEQ   = 5'd25,
    OP_BGT   = 5'd26,
    OP_BUF   = 5'd27,
    OP_BOF   = 5'd28,
    OP_PASS  = 5'd29
  } xu_op_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic eq;
    logic gt;
  } xu_flags_t;

endpackage

// File: rtl/xu_alu.sv
module xu_alu
  import xu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  xu_op_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] res,
  output logic              arith_en,
  output logic              arith_ovf,
  output logic              arith_unf,
  output logic              cmp_en,
  output logic              cmp_gt,
  output logic              cmp_eq
);

  localparam int SH_W = $clog2(DATA_W);
  localparam int WW   = 2 * DATA_W;
  localparam logic signed [WW-1:0] MAX_W = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [WW-1:0] MIN_W = ~MAX_W;

  function automatic logic [DATA_W-1:0] f_sra(input logic [DATA_W-1:0] x,
                                              input logic [SH_W-1:0]   n);
    logic signed [DATA_W-1:0] t;
    t = $signed(x);
    return DATA_W'(t >>> n);
  endfunction

  // one extra bit keeps the most-negative / -1 case from overflowing
  function automatic logic [DATA_W-1:0] f_quot(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    logic signed [DATA_W:0] xs, ys, q;
    xs = {x[DATA_W-1], x};
    ys = {y[DATA_W-1], y};
    if (y == '0) return '0;
    q = xs / ys;
    return q[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] f_rem(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    logic signed [DATA_W:0] xs, ys, r;
    xs = {x[DATA_W-1], x};
    ys = {y[DATA_W-1], y};
    if (y == '0) return '0;
    r = xs % ys;
    return r[DATA_W-1:0];
  endfunction

  function automatic logic signed [WW-1:0] f_wide(input xu_op_e o,
                                                  input logic [DATA_W-1:0] x,
                                                  input logic [DATA_W-1:0] y);
    logic signed [WW-1:0] sx, sy;
    sx = {{DATA_W{x[DATA_W-1]}}, x};
    sy = {{DATA_W{y[DATA_W-1]}}, y};
    case (o)
      OP_MUL:          return sx * sy;
      OP_SUB, OP_SUBI: return sx - sy;
      default:         return sx + sy;
    endcase
  endfunction

  logic [DATA_W-1:0]    arith_y;
  logic signed [WW-1:0] wide;

  always_comb begin
    arith_y   = (op == OP_ADDI || op == OP_SUBI) ? imm : b;
    wide      = f_wide(op, a, arith_y);
    arith_en  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
                (op == OP_ADDI) || (op == OP_SUBI);
    arith_ovf = wide > MAX_W;
    arith_unf = wide < MIN_W;
    cmp_en    = (op == OP_CMP);
    cmp_gt    = $signed(a) > $signed(b);
    cmp_eq    = (a == b);
  end

  always_comb begin
    case (op)
      OP_ADD:            res = a + b;
      OP_SUB:            res = a - b;
      OP_MUL:            res = a * b;
      OP_QUOT:           res = f_quot(a, b);
      OP_REM:            res = f_rem(a, b);
      OP_SHR:            res = f_sra(a, b[SH_W-1:0]);
      OP_SHL:            res = a << b[SH_W-1:0];
      OP_AND:            res = a & b;
      OP_OR:             res = a | b;
      OP_XOR:            res = a ^ b;
      OP_NOT:            res = ~a;
      OP_ADDI:           res = a + imm;
      OP_SUBI:           res = a - imm;
      OP_SHRI:           res = f_sra(a, imm[SH_W-1:0]);
      OP_SHLI:           res = a << imm[SH_W-1:0];
      OP_ANDI:           res = a & imm;
      OP_ORI:            res = a | imm;
      OP_XORI:           res = a ^ imm;
      OP_LOAD, OP_STORE: res = a + imm;
      OP_JMP, OP_JAL:    res = a + b;
      OP_JRL:            res = pc + b;
      default:           res = a;
    endcase
  end

endmodule

// File: rtl/xu_branch.sv
module xu_branch
  import xu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  xu_op_e            op,
  input  logic [ADDR_W-1:0] pc_lo,
  input  logic [ADDR_W-1:0] ofs_lo,
  input  xu_flags_t         flags,
  output logic              is_br,
  output logic [DATA_W-1:0] br_res
);

  logic              taken;
  logic [ADDR_W-1:0] tgt;

  always_comb begin
    is_br = 1'b1;
    case (op)
      OP_BEQ:  taken = flags.eq;
      OP_BGT:  taken = flags.gt;
      OP_BUF:  taken = flags.unf;
      OP_BOF:  taken = flags.ovf;
      default: begin
        taken = 1'b0;
        is_br = 1'b0;
      end
    endcase
    tgt    = pc_lo + ofs_lo;
    br_res = taken ? DATA_W'(tgt) : '1;
  end

  // R8
  always_comb begin
    if (is_br) begin
      br_range_chk: assert ((br_res == '1) || ((br_res >> ADDR_W) == '0));
    end
  end

endmodule

// File: rtl/xu_flags.sv
module xu_flags
  import xu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  logic      cmp_en,
  input  logic      gt,
  input  logic      eq,
  input  logic      arith_en,
  input  logic      ovf,
  input  logic      unf,
  output xu_flags_t flags
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (upd) begin
      if (cmp_en) begin
        flags.gt <= gt;
        flags.eq <= eq;
      end
      if (arith_en) begin
        flags.ovf <= ovf;
        flags.unf <= unf;
      end
    end
  end

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags));

  // R7
  range_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags.ovf, flags.unf}));

  // R6
  cmp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags.gt, flags.eq}));

endmodule

// File: rtl/xu_exec.sv
module xu_exec
  import xu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_imm,
  input  logic [DATA_W-1:0] in_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res,
  output logic [3:0]        out_flags
);

  xu_op_e            op;
  logic              accept;
  logic [DATA_W-1:0] alu_res, br_res, fin_res;
  logic              arith_en, arith_ovf, arith_unf;
  logic              cmp_en, cmp_gt, cmp_eq;
  logic              is_br;
  logic              div_by_zero;
  xu_flags_t         flags;

  assign op          = xu_op_e'(in_op);
  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;
  assign div_by_zero = accept && (op == OP_QUOT || op == OP_REM) && (in_b == '0);

  xu_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (op),
    .a         (in_a),
    .b         (in_b),
    .imm       (in_imm),
    .pc        (in_pc),
    .res       (alu_res),
    .arith_en  (arith_en),
    .arith_ovf (arith_ovf),
    .arith_unf (arith_unf),
    .cmp_en    (cmp_en),
    .cmp_gt    (cmp_gt),
    .cmp_eq    (cmp_eq)
  );

  xu_branch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_branch (
    .op     (op),
    .pc_lo  (in_pc[ADDR_W-1:0]),
    .ofs_lo (in_b[ADDR_W-1:0]),
    .flags  (flags),
    .is_br  (is_br),
    .br_res (br_res)
  );

  xu_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (accept),
    .cmp_en   (cmp_en),
    .gt       (cmp_gt),
    .eq       (cmp_eq),
    .arith_en (arith_en),
    .ovf      (arith_ovf),
    .unf      (arith_unf),
    .flags    (flags)
  );

  assign fin_res   = is_br ? br_res : alu_res;
  assign out_flags = flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_res   <= fin_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R4
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |=> (out_res == '0));

endmodule

// File: tb/test_xu_exec.sv
module test_xu_exec;

  localparam int DW = 8;
  localparam int AW = 4;
  localparam longint MASK  = (longint'(1) << DW) - 1;
  localparam longint AMASK = (longint'(1) << AW) - 1;
  localparam longint SMAX  = (longint'(1) << (DW - 1)) - 1;
  localparam longint SMIN  = -(longint'(1) << (DW - 1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [4:0]    in_op = '0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_imm = '0, in_pc = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_res;
  logic [3:0]    out_flags;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [3:0] m_flags = '0;   // {ovf, unf, eq, gt}

  always #5 clk = ~clk;

  xu_exec #(.DATA_W(DW), .ADDR_W(AW)) i_xu_exec (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_op (in_op),
    .in_a (in_a), .in_b (in_b), .in_imm (in_imm), .in_pc (in_pc),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_res (out_res), .out_flags (out_flags)
  );

  function automatic longint sv(input logic [DW-1:0] v);
    return v[DW-1] ? longint'(v) - (longint'(1) << DW) : longint'(v);
  endfunction

  function automatic string tag_of(input int op);
    if (op <= 11) begin
      if (op == 4 || op == 5) return "R4";
      if (op == 6 || op == 7) return "R3";
      if (op == 0) return "R9";
      return "R1";
    end
    if (op <= 18) return (op == 14 || op == 15) ? "R3" : "R2";
    if (op == 21) return "R6";
    if (op <= 24) return "R5";
    if (op <= 28) return "R8";
    return "R9";
  endfunction

  // reference model: result and updated flags
  task automatic predict(input int op, input logic [DW-1:0] a, b, imm, pc,
                         output logic [DW-1:0] r);
    longint A = sv(a), B = sv(b), I = sv(imm), w;
    int     shb = int'(b) % DW, shi = int'(imm) % DW;
    bit     take;
    w = 0;
    case (op)
      1:  r = DW'(A + B);
      2:  r = DW'(A - B);
      3:  r = DW'(A * B);
      4:  r = (B == 0) ? '0 : DW'(A / B);
      5:  r = (B == 0) ? '0 : DW'(A % B);
      6:  r = DW'(A >>> shb);
      7:  r = DW'((A << shb) & MASK);
      8:  r = a & b;
      9:  r = a | b;
      10: r = a ^ b;
      11: r = ~a;
      12: r = DW'(A + I);
      13: r = DW'(A - I);
      14: r = DW'(A >>> shi);
      15: r = DW'((A << shi) & MASK);
      16: r = a & imm;
      17: r = a | imm;
      18: r = a ^ imm;
      19, 20: r = DW'(A + I);
      22, 23: r = DW'(A + B);
      24: r = DW'(longint'(pc) + B);
      25, 26, 27, 28: begin
        take = (op == 25) ? m_flags[1] : (op == 26) ? m_flags[0] :
               (op == 27) ? m_flags[2] : m_flags[3];
        r = take ? DW'((longint'(pc) + B) & AMASK) : '1;
      end
      default: r = a;
    endcase
    if (op == 21) begin
      m_flags[0] = (A > B);
      m_flags[1] = (A == B);
    end
    if (op == 1 || op == 2 || op == 3 || op == 12 || op == 13) begin
      case (op)
        1:  w = A + B;
        2:  w = A - B;
        3:  w = A * B;
        12: w = A + I;
        default: w = A - I;
      endcase
      m_flags[3] = (w > SMAX);
      m_flags[2] = (w < SMIN);
    end
  endtask

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after the result shows
  task automatic apply(input int op, input logic [DW-1:0] a, b, imm, pc);
    logic [DW-1:0] r;
    bit bad;
    in_valid = 1'b1;
    in_op = 5'(op); in_a = a; in_b = b; in_imm = imm; in_pc = pc;
    predict(op, a, b, imm, pc, r);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    bad = (out_valid !== 1'b1) || (out_res !== r) || (out_flags !== m_flags);
    if (bad) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%0h b=%0h: actual res=%0h flags=%0h valid=%0b expected res=%0h flags=%0h valid=1",
               tag_of(op), op, a, b, out_res, out_flags, out_valid, r, m_flags);
    end
  endtask

  initial begin
    logic [DW-1:0] bset [8];
    logic [DW-1:0] held_res;
    logic [3:0]    held_flags;
    bset = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h7F, 8'h80, 8'hC5, 8'hFF};

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "out_valid after reset", longint'(out_valid), 0);
    check("R11", "flags after reset", longint'(out_flags), 0);
    check("R10", "in_ready after reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: every first operand, a set of second operands, every opcode
    for (int a = 0; a < 256; a++) begin
      for (int bi = 0; bi < 8; bi++) begin
        for (int op = 0; op < 32; op++) begin
          apply(op, DW'(a), bset[bi], bset[bi] ^ 8'h3C, DW'(a * 5 + bi * 3));
        end
      end
    end

    // R10: stall holds result; a waiting CMP must not touch flags
    apply(21, 8'h10, 8'h10, 8'h00, 8'h00);   // EQ set, GT clear
    held_res = out_res;
    held_flags = out_flags;
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 5'd21; in_a = 8'h30; in_b = 8'h05;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check("R10", "in_ready while stalled", longint'(in_ready), 0);
      check("R10", "held result", longint'(out_res), longint'(held_res));
      check("R11", "flags while stalled", longint'(out_flags), longint'(held_flags));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_flags[0] = 1'b1; m_flags[1] = 1'b0;
    check("R6", "result after stall release", longint'(out_res), 48);
    check("R6", "flags after stall release", longint'(out_flags), longint'(m_flags));

    // R11: bubble leaves flags alone and empties the stage
    in_valid = 1'b0; in_op = 5'd1; in_a = 8'h7F; in_b = 8'h7F;
    @(posedge clk);
    @(negedge clk);
    check("R10", "out_valid after bubble", longint'(out_valid), 0);
    check("R11", "flags after bubble", longint'(out_flags), longint'(m_flags));

    // R8 after a directed compare: GT set so BGT taken with wrap
    apply(21, 8'h05, 8'hFE, 8'h00, 8'h00);
    apply(26, 8'h00, 8'h03, 8'h00, 8'hFE);   // 0xFE+3 -> 0x01
    apply(25, 8'h00, 8'h03, 8'h00, 8'hFE);   // EQ clear -> all ones

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule